// File: doc/BRIEF.md
# Selectable Tag Line Encoder

This block turns a serial stream of data bits into the control line that drives the load-modulation switch of a passive tag. It has three selectable line codes: Manchester, biphase and carrier-rate phase-shift keying. The clock is the carrier itself, and every duration is counted in carrier cycles. A bit lasts 64 or 32 cycles in the two edge-coded modes and 16 cycles in the phase-shift mode.

The bit source pulses `bit_stb` for one cycle at the start of each bit period. It presents the bit value, the mode and the rate on that same cycle. The block samples these inputs only on a strobe, so the source may change them freely between strobes. The source is responsible for placing strobes one bit period apart. The block measures the mid-bit point from the last strobe.

The output `mod_ctl` is low when the high-current switch should be on. After reset the output is high (switch off), and the block stays idle until the first strobe.

Top module: `rfid_line_coder`

## Requirements
- R1: While `rst_n` is low, and after reset until the first strobe, `mod_ctl` is 1.
- R2: Manchester (`mode_sel`=0): on the edge that samples a strobe, `mod_ctl` takes the bit value. At mid-bit it takes the inverted bit value, so a 1 is sent high then low and a 0 is sent low then high.
- R3: The mid-bit point falls a number of cycles after the strobe edge equal to half the bit period. The bit period is 64 cycles when `rate_fast`=0 and 32 cycles when `rate_fast`=1.
- R4: Biphase (`mode_sel`=1): `mod_ctl` inverts on every edge that samples a strobe.
- R5: Biphase: a 0 bit adds one more inversion at mid-bit. A 1 bit holds its level until the next strobe.
- R6: Phase-shift mode (`mode_sel`=2): `mod_ctl` inverts on every clock edge that does not sample a strobe. On a strobe edge a 1 bit also inverts it, continuing the pattern. `rate_fast` has no effect in this mode.
- R7: Phase-shift mode: on a strobe edge a 0 bit holds `mod_ctl` for one extra cycle, which reverses the phase of the toggle pattern.
- R8: Changes on `mode_sel`, `rate_fast` and `data_bit` while `bit_stb` is low do not affect `mod_ctl` before the next strobe.
- R9: Idle mode (`mode_sel`=3) drives `mod_ctl` to 1 from the strobe edge until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Line code for the bit: 0 Manchester, 1 biphase, 2 phase-shift, 3 idle |
| rate_fast | input | 1 | 0 selects a 64-cycle bit, 1 a 32-cycle bit (edge-coded modes) |
| data_bit | input | 1 | Bit value, sampled with the strobe |
| bit_stb | input | 1 | One-cycle pulse at each bit boundary |
| mod_ctl | output | 1 | Modulator control, low means switch on |

## Verification
`mod_ctl` is a register, so a strobe changes it on the same rising edge that samples the strobe. The mid-bit change comes exactly half a bit period of edges later. In phase-shift mode a change is due on every edge. The bench has a reference model that advances on each rising edge from the driven inputs alone. It compares the model with `mod_ctl` at every falling edge, so each result is checked in the cycle it is due and never sampled at the edge that produces it. All stimulus is driven at falling edges, including the disturbances between strobes.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  typedef enum logic [1:0] {
    MD_MAN  = 2'd0,
    MD_BIP  = 2'd1,
    MD_PSK  = 2'd2,
    MD_IDLE = 2'd3
  } rlc_mode_e;

  // Carrier cycles in one bit for a given code and rate choice.
  function automatic int unsigned bit_cycles(input rlc_mode_e m, input logic fast,
                                             input int unsigned slow_c,
                                             input int unsigned fast_c,
                                             input int unsigned psk_c);
    if (m == MD_PSK) return psk_c;
    return fast ? fast_c : slow_c;
  endfunction

  // Mid-bit offset from the boundary edge.
  function automatic int unsigned mid_offset(input int unsigned cycles);
    return cycles / 2;
  endfunction

  // Level after a boundary edge.
  function automatic logic edge_level(input rlc_mode_e m, input logic b, input logic prev);
    case (m)
      MD_MAN:  return b;
      MD_BIP:  return ~prev;
      MD_PSK:  return b ? ~prev : prev;
      default: return 1'b1;
    endcase
  endfunction

  // Level after a non-boundary edge.
  function automatic logic run_level(input rlc_mode_e m, input logic b, input logic mid,
                                     input logic prev);
    case (m)
      MD_MAN:  return mid ? ~b : prev;
      MD_BIP:  return (mid && !b) ? ~prev : prev;
      MD_PSK:  return ~prev;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/rlc_bit_latch.sv
module rlc_bit_latch
  import rlc_pkg::*;
#(
  parameter int unsigned SLOW_CYC = 64,
  parameter int unsigned FAST_CYC = 32,
  parameter int unsigned PSK_CYC  = 16,
  parameter int unsigned CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  rlc_mode_e        mode_in,
  input  logic             fast_in,
  input  logic             bit_in,
  output rlc_mode_e        cur_mode,
  output logic             cur_bit,
  output logic [CNT_W-1:0] half_cnt
);

  logic [CNT_W-1:0] half_new;
  assign half_new = CNT_W'(mid_offset(bit_cycles(mode_in, fast_in, SLOW_CYC, FAST_CYC, PSK_CYC)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode <= MD_IDLE;
      cur_bit  <= 1'b1;
      half_cnt <= CNT_W'(mid_offset(SLOW_CYC));
    end else if (stb) begin
      cur_mode <= mode_in;
      cur_bit  <= bit_in;
      half_cnt <= half_new;
    end
  end

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(cur_mode) && $stable(cur_bit) && $stable(half_cnt)));

endmodule

// File: rtl/rlc_bit_timer.sv
module rlc_bit_timer #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [CNT_W-1:0] half_cnt,
  output logic             mid_evt
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = (cnt == CNT_TOP) ? cnt : cnt + 1'b1;
  assign mid_evt = !stb && (cnt_nxt == half_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= CNT_TOP;
    else if (stb) cnt <= '0;
    else          cnt <= cnt_nxt;
  end

  assert_mid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mid_evt |=> !mid_evt);

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (cnt == '0));

endmodule

// File: rtl/rlc_symbol_gen.sv
module rlc_symbol_gen
  import rlc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stb,
  input  rlc_mode_e mode_in,
  input  logic      bit_in,
  input  rlc_mode_e cur_mode,
  input  logic      cur_bit,
  input  logic      mid_evt,
  output logic      mod_q
);

  logic mod_nxt;

  always_comb begin
    if (stb) mod_nxt = edge_level(mode_in, bit_in, mod_q);
    else     mod_nxt = run_level(cur_mode, cur_bit, mid_evt, mod_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_q <= 1'b1;
    else        mod_q <= mod_nxt;
  end

  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MD_IDLE) |-> mod_q);

  assert_man_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_evt && cur_mode == MD_MAN) |=> (mod_q == !$past(cur_bit)));

  assert_bip_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && mode_in == MD_BIP) |=> (mod_q != $past(mod_q)));

  assert_bip_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && cur_mode == MD_BIP && cur_bit) |=> $stable(mod_q));

  assert_psk_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && cur_mode == MD_PSK) |=> (mod_q != $past(mod_q)));

  assert_psk_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && mode_in == MD_PSK && !bit_in) |=> $stable(mod_q));

endmodule

// File: rtl/rfid_line_coder.sv
module rfid_line_coder
  import rlc_pkg::*;
#(
  parameter int unsigned SLOW_CYC = 64,
  parameter int unsigned FAST_CYC = 32,
  parameter int unsigned PSK_CYC  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       rate_fast,
  input  logic       data_bit,
  input  logic       bit_stb,
  output logic       mod_ctl
);

  localparam int unsigned CNT_W = $clog2(SLOW_CYC) + 1;

  rlc_mode_e        mode_in;
  rlc_mode_e        cur_mode;
  logic             cur_bit;
  logic [CNT_W-1:0] half_cnt;
  logic             mid_evt;

  assign mode_in = rlc_mode_e'(mode_sel);

  rlc_bit_latch #(
    .SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC), .PSK_CYC(PSK_CYC), .CNT_W(CNT_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .stb(bit_stb), .mode_in(mode_in), .fast_in(rate_fast),
    .bit_in(data_bit), .cur_mode(cur_mode), .cur_bit(cur_bit), .half_cnt(half_cnt)
  );

  rlc_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .stb(bit_stb), .half_cnt(half_cnt), .mid_evt(mid_evt)
  );

  rlc_symbol_gen u_gen (
    .clk(clk), .rst_n(rst_n), .stb(bit_stb), .mode_in(mode_in), .bit_in(data_bit),
    .cur_mode(cur_mode), .cur_bit(cur_bit), .mid_evt(mid_evt), .mod_q(mod_ctl)
  );

  assert_reset_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> mod_ctl);

endmodule

// File: tb/sim_rfid_line_coder.sv
`timescale 1ns/100ps
module sim_rfid_line_coder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd3;
  logic       rate_fast = 1'b0;
  logic       data_bit = 1'b0;
  logic       bit_stb = 1'b0;
  logic       mod_ctl;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string req = "R1";

  // reference model state
  bit exp_out = 1'b1;
  int m_mode = 3;
  int m_bit = 1;
  int m_per = 64;
  int m_since = 1000;

  always #2.5 clk = ~clk;

  rfid_line_coder u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_fast(rate_fast),
    .data_bit(data_bit), .bit_stb(bit_stb), .mod_ctl(mod_ctl)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_out = 1'b1; m_mode = 3; m_since = 1000;
    end else if (bit_stb) begin
      m_mode = int'(mode_sel);
      m_bit = int'(data_bit);
      m_per = (m_mode == 2) ? 16 : (rate_fast ? 32 : 64);
      m_since = 0;
      if (m_mode == 0)      exp_out = data_bit;
      else if (m_mode == 1) exp_out = !exp_out;
      else if (m_mode == 2) begin if (data_bit) exp_out = !exp_out; end
      else                  exp_out = 1'b1;
    end else begin
      m_since++;
      if (m_mode == 0)      begin if (m_since == m_per / 2) exp_out = (m_bit == 0); end
      else if (m_mode == 1) begin if (m_since == m_per / 2 && m_bit == 0) exp_out = !exp_out; end
      else if (m_mode == 2) exp_out = !exp_out;
      else                  exp_out = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (mod_ctl !== exp_out) begin
        failures++;
        $display("FAIL %s cycle=%0d mod_ctl actual=%b expected=%b", req, cycles, mod_ctl, exp_out);
      end
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic send(input int m, input bit f, input bit b, input string tag, input bit disturb);
    int per;
    per = (m == 2) ? 16 : (f ? 32 : 64);
    @(negedge clk);
    req = tag; mode_sel = 2'(m); rate_fast = f; data_bit = b; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    for (int i = 1; i < per; i++) begin
      if (disturb && i == 3) begin
        mode_sel = ~2'(m); rate_fast = ~f; data_bit = ~b;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    req = "R1";
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // Manchester, 64-cycle bits
    send(0, 0, 1, "R2", 0); send(0, 0, 0, "R2", 0);
    send(0, 0, 0, "R2", 0); send(0, 0, 1, "R2", 0);
    // Manchester, 32-cycle bits: mid-bit moves to 16
    send(0, 1, 1, "R3", 0); send(0, 1, 0, "R3", 0); send(0, 1, 1, "R3", 0);
    // biphase
    send(1, 0, 1, "R4", 0); send(1, 0, 1, "R4", 0); send(1, 0, 0, "R5", 0);
    send(1, 0, 1, "R4", 0); send(1, 1, 0, "R5", 0); send(1, 1, 0, "R5", 0);
    send(1, 1, 1, "R5", 0);
    // phase-shift, both rate settings
    send(2, 0, 1, "R6", 0); send(2, 1, 1, "R6", 0); send(2, 0, 0, "R7", 0);
    send(2, 1, 1, "R6", 0); send(2, 0, 0, "R7", 0); send(2, 0, 0, "R7", 0);
    // inputs disturbed between strobes
    send(0, 0, 1, "R8", 1); send(1, 1, 0, "R8", 1); send(2, 0, 0, "R8", 1);
    send(0, 1, 0, "R8", 1);
    // idle code
    send(3, 0, 0, "R9", 0); send(3, 1, 1, "R9", 0);
    send(0, 1, 0, "R2", 0);
    // reset mid-bit returns the line high
    @(negedge clk);
    req = "R1"; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule